// File: doc/BRIEF.md
# D-PHY Clock Lane Transmit Sequencer

This block drives the line state of one transmit clock lane in a digital model of a D-PHY link. While the lane is quiet it holds the low-power stop state. When a request arrives it steps the lane through a fixed series of low-power and high-speed states until a continuous high-speed clock is running. When the request is withdrawn and every data lane is back in low power, it winds the clock down and returns the lane to stop.

Every interval in these series is a programmable count of controller clock cycles. A small set of interval registers holds the counts. A write to these registers takes effect only while the lane rests in stop with no sequence in progress.

The block also provides a ready signal for the data-lane sequencers. A data lane may begin its own high-speed entry only while ready is high. Ready rises only after the clock has toggled for the programmed pre interval.

Top module: `dphy_clk_lane_seq`

## Requirements
- R1: During reset and afterwards, until a request is sampled, `line_state` is 0 (stop, LP-11), and both `hs_clk_en` and `clk_ready` are low.
- R2: `line_state` uses these codes: 0 = LP-11, 1 = LP-01, 2 = LP-00, 3 = HS-0, 4 = toggling HS clock. `hs_clk_en` is high exactly when the code is 4. A request sampled in stop starts the entry series on the following cycle. The series is LP-01 for `lpx` cycles, then LP-00 for `prepare` cycles, then HS-0 for `zero` cycles, and then toggling.
- R3: `clk_ready` stays low for the first `pre` toggling cycles and rises on the cycle that follows them.
- R4: While `clk_ready` is high, sampling `hs_req` low and `data_lp` high starts the exit series. On the next cycle `clk_ready` drops. The clock keeps toggling for `post` cycles, HS-0 follows for `trail` cycles, and then the lane returns to LP-11.
- R5: While `data_lp` is low, the clock keeps toggling and `clk_ready` stays high, even if `hs_req` is low.
- R6: A request withdrawn during the entry series does not shorten that series. The entry completes, `clk_ready` is high for one cycle, and the exit series of R4 follows.
- R7: After trail the lane holds LP-11 for `lpx` cycles before a new request is sampled. With `hs_req` held high, the lane therefore shows LP-11 for `lpx`+1 cycles before LP-01.
- R8: A write (`cfg_we` high) updates the interval registers only while the lane is idle in stop. A write during any phase of a sequence, the closing LP-11 hold included, is ignored.
- R9: An interval value of 0 behaves as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the interval registers |
| cfg_lpx | input | CNT_W | Low-power state length, in cycles |
| cfg_prepare | input | CNT_W | LP-00 length before HS-0, in cycles |
| cfg_zero | input | CNT_W | HS-0 length before toggling, in cycles |
| cfg_pre | input | CNT_W | Toggling cycles before ready rises |
| cfg_post | input | CNT_W | Toggling cycles after release |
| cfg_trail | input | CNT_W | HS-0 length after the last clock bit, in cycles |
| hs_req | input | 1 | High-speed clock request, level |
| data_lp | input | 1 | All data lanes are in low power |
| line_state | output | 3 | Lane state code (see R2) |
| hs_clk_en | output | 1 | High-speed clock toggling enable |
| clk_ready | output | 1 | Data lanes may enter high speed |

## Verification
The sequence is exercised with several request patterns. A plain request followed by a plain release measures each phase length against its register value. A release made while a data lane is still busy shows that the post interval waits for `data_lp`. A request pulse that ends during LP-01 shows that the entry series cannot be cut short. A request reasserted during post shows the LP-11 hold before re-entry.

Two register patterns are also used. Writes made while the clock runs, followed by writes made at rest, tell ignored updates from accepted ones. All-zero intervals probe the one-cycle floor.

// File: rtl/dphyclk_pkg.sv
package dphyclk_pkg;

   // Line state codes seen at the block's output
   localparam logic [2:0] LN_STOP  = 3'd0;
   localparam logic [2:0] LN_LP01  = 3'd1;
   localparam logic [2:0] LN_LP00  = 3'd2;
   localparam logic [2:0] LN_HS0   = 3'd3;
   localparam logic [2:0] LN_HSCLK = 3'd4;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_ENTRY_LP01,
      PH_PREP,
      PH_ZERO,
      PH_PRE,
      PH_RUN,
      PH_POST,
      PH_TRAIL,
      PH_HOLD
   } phase_t;

   // Interval register slots
   localparam int IVL_NUM     = 6;
   localparam int IVL_LPX     = 0;
   localparam int IVL_PREPARE = 1;
   localparam int IVL_ZERO    = 2;
   localparam int IVL_PRE     = 3;
   localparam int IVL_POST    = 4;
   localparam int IVL_TRAIL   = 5;

endpackage

// File: rtl/dphyclk_cfg_bank.sv
module dphyclk_cfg_bank #(
   parameter int W = 8,
   parameter int N = 6,
   parameter int RST_VAL = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic                idle,
   input  logic [N-1:0][W-1:0] wr_val,
   output logic [N-1:0][W-1:0] val
);

   localparam logic [W-1:0] RST_W = W'(RST_VAL);

   if (N < 1) begin : g_bad_n
      $error("dphyclk_cfg_bank: N must be at least 1");
   end

   logic accept;
   assign accept = we && idle;

   for (genvar i = 0; i < N; i++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val[i] <= RST_W;
         else if (accept)
            val[i] <= wr_val[i];
      end
   end

   // R8: the registers hold their value whenever the lane is not idle
   a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> $stable(val));

endmodule

// File: rtl/dphyclk_ivl_timer.sv
module dphyclk_ivl_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_len,
   output logic         done
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= (load_len == '0) ? '0 : load_len - W'(1);
      else if (cnt != '0)
         cnt <= cnt - W'(1);
   end

   assign done = (cnt == '0);

   // R9: an expired timer never wraps around
   a_r9_timer_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !load) |=> done);

endmodule

// File: rtl/dphyclk_fsm.sv
module dphyclk_fsm
   import dphyclk_pkg::*;
#(
   parameter int W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      hs_req,
   input  logic                      data_lp,
   input  logic                      tmr_done,
   input  logic [IVL_NUM-1:0][W-1:0] ivl,
   output logic                      tmr_load,
   output logic [W-1:0]              tmr_len,
   output logic                      idle,
   output logic [2:0]                line_d,
   output logic                      hs_en_d,
   output logic                      ready_d
);

   phase_t cur, nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur <= PH_IDLE;
      else
         cur <= nxt;
   end

   always_comb begin
      nxt = cur;
      unique case (cur)
         PH_IDLE:       if (hs_req)             nxt = PH_ENTRY_LP01;
         PH_ENTRY_LP01: if (tmr_done)           nxt = PH_PREP;
         PH_PREP:       if (tmr_done)           nxt = PH_ZERO;
         PH_ZERO:       if (tmr_done)           nxt = PH_PRE;
         PH_PRE:        if (tmr_done)           nxt = PH_RUN;
         PH_RUN:        if (!hs_req && data_lp) nxt = PH_POST;
         PH_POST:       if (tmr_done)           nxt = PH_TRAIL;
         PH_TRAIL:      if (tmr_done)           nxt = PH_HOLD;
         PH_HOLD:       if (tmr_done)           nxt = PH_IDLE;
         default:                               nxt = PH_IDLE;
      endcase
   end

   assign tmr_load = (nxt != cur);

   always_comb begin
      unique case (nxt)
         PH_ENTRY_LP01: tmr_len = ivl[IVL_LPX];
         PH_PREP:       tmr_len = ivl[IVL_PREPARE];
         PH_ZERO:       tmr_len = ivl[IVL_ZERO];
         PH_PRE:        tmr_len = ivl[IVL_PRE];
         PH_POST:       tmr_len = ivl[IVL_POST];
         PH_TRAIL:      tmr_len = ivl[IVL_TRAIL];
         PH_HOLD:       tmr_len = ivl[IVL_LPX];
         default:       tmr_len = '0;
      endcase
   end

   always_comb begin
      unique case (cur)
         PH_ENTRY_LP01:          line_d = LN_LP01;
         PH_PREP:                line_d = LN_LP00;
         PH_ZERO, PH_TRAIL:      line_d = LN_HS0;
         PH_PRE, PH_RUN, PH_POST: line_d = LN_HSCLK;
         default:                line_d = LN_STOP;
      endcase
   end

   assign hs_en_d = (cur == PH_PRE) || (cur == PH_RUN) || (cur == PH_POST);
   assign ready_d = (cur == PH_RUN);
   assign idle    = (cur == PH_IDLE);

   // R2: entry order from stop
   a_r2_stop_next: assert property (@(posedge clk) disable iff (!rst_n)
      (line_d == LN_STOP) |=> (line_d == LN_STOP || line_d == LN_LP01));
   a_r2_lp01_next: assert property (@(posedge clk) disable iff (!rst_n)
      (line_d == LN_LP01) |=> (line_d == LN_LP01 || line_d == LN_LP00));
   a_r2_lp00_next: assert property (@(posedge clk) disable iff (!rst_n)
      (line_d == LN_LP00) |=> (line_d == LN_LP00 || line_d == LN_HS0));
   // R3: ready only while toggling, and only after the pre phase
   a_r3_ready_toggling: assert property (@(posedge clk) disable iff (!rst_n)
      ready_d |-> (line_d == LN_HSCLK && hs_en_d));
   a_r3_ready_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_d) |-> ($past(cur) == PH_PRE));
   // R4: ready falls only on a sampled release
   a_r4_ready_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready_d) |-> ($past(!hs_req) && $past(data_lp)));
   // R5: a busy data lane keeps the clock up
   a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_d && !data_lp) |=> ready_d);
   // R7: the closing hold returns only to idle
   a_r7_hold_next: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PH_HOLD) |=> (cur == PH_HOLD || cur == PH_IDLE));

endmodule

// File: rtl/dphy_clk_lane_seq.sv
module dphy_clk_lane_seq
   import dphyclk_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CNT_W-1:0] cfg_lpx,
   input  logic [CNT_W-1:0] cfg_prepare,
   input  logic [CNT_W-1:0] cfg_zero,
   input  logic [CNT_W-1:0] cfg_pre,
   input  logic [CNT_W-1:0] cfg_post,
   input  logic [CNT_W-1:0] cfg_trail,
   input  logic             hs_req,
   input  logic             data_lp,
   output logic [2:0]       line_state,
   output logic             hs_clk_en,
   output logic             clk_ready
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
      $error("dphy_clk_lane_seq: CNT_W must lie in 2..32");
   end

   logic [IVL_NUM-1:0][CNT_W-1:0] wr_val, ivl;
   logic             idle, tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_len;
   logic [2:0]       line_d;
   logic             hs_en_d, ready_d;

   always_comb begin
      wr_val[IVL_LPX]     = cfg_lpx;
      wr_val[IVL_PREPARE] = cfg_prepare;
      wr_val[IVL_ZERO]    = cfg_zero;
      wr_val[IVL_PRE]     = cfg_pre;
      wr_val[IVL_POST]    = cfg_post;
      wr_val[IVL_TRAIL]   = cfg_trail;
   end

   dphyclk_cfg_bank #(.W(CNT_W), .N(IVL_NUM), .RST_VAL(1)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .idle   (idle),
      .wr_val (wr_val),
      .val    (ivl)
   );

   dphyclk_ivl_timer #(.W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_len (tmr_len),
      .done     (tmr_done)
   );

   dphyclk_fsm #(.W(CNT_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .hs_req   (hs_req),
      .data_lp  (data_lp),
      .tmr_done (tmr_done),
      .ivl      (ivl),
      .tmr_load (tmr_load),
      .tmr_len  (tmr_len),
      .idle     (idle),
      .line_d   (line_d),
      .hs_en_d  (hs_en_d),
      .ready_d  (ready_d)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            line_state <= LN_STOP;
            hs_clk_en  <= 1'b0;
            clk_ready  <= 1'b0;
         end else begin
            line_state <= line_d;
            hs_clk_en  <= hs_en_d;
            clk_ready  <= ready_d;
         end
      end
   end else begin : g_out_comb
      assign line_state = line_d;
      assign hs_clk_en  = hs_en_d;
      assign clk_ready  = ready_d;
   end

   // R1: quiet outputs while reset is applied
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (line_state == LN_STOP && !hs_clk_en && !clk_ready));

endmodule

// File: tb/sim_dphy_clk_lane_seq.sv
module sim_dphy_clk_lane_seq;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cfg_we;
   logic [W-1:0] cfg_lpx, cfg_prepare, cfg_zero, cfg_pre, cfg_post, cfg_trail;
   logic         hs_req, data_lp;
   logic [2:0]   line_state;
   logic         hs_clk_en, clk_ready;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   dphy_clk_lane_seq #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
      .cfg_lpx(cfg_lpx), .cfg_prepare(cfg_prepare), .cfg_zero(cfg_zero),
      .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_trail(cfg_trail),
      .hs_req(hs_req), .data_lp(data_lp),
      .line_state(line_state), .hs_clk_en(hs_clk_en), .clk_ready(clk_ready)
   );

   // Samples n cycles at negedges; one check per segment
   task automatic expect_seg(input logic [2:0] code, input logic rdy,
                             input int n, input string tag);
      int bad = 0;
      logic [2:0] al = '0;
      logic ar = 1'b0, ae = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (line_state !== code || clk_ready !== rdy ||
             hs_clk_en !== (code == 3'd4)) begin
            if (bad == 0) begin al = line_state; ar = clk_ready; ae = hs_clk_en; end
            bad++;
         end
      end
      checks++;
      if (bad != 0) begin
         failures++;
         $display("FAIL %s: line=%0d ready=%0b en=%0b expected line=%0d ready=%0b en=%0b (%0d of %0d cycles wrong)",
                  tag, al, ar, ae, code, rdy, (code == 3'd4), bad, n);
      end
   endtask

   task automatic write_cfg(input int l, input int pr, input int z,
                            input int pe, input int po, input int t);
      cfg_lpx = W'(l); cfg_prepare = W'(pr); cfg_zero = W'(z);
      cfg_pre = W'(pe); cfg_post = W'(po); cfg_trail = W'(t);
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Entry with lpx=3 prepare=2 zero=4 pre=5, then nr ready cycles
   task automatic entry_default(input int nr, input string tag);
      expect_seg(3'd1, 1'b0, 3, {tag, " R2 LP-01 lpx"});
      expect_seg(3'd2, 1'b0, 2, {tag, " R2 LP-00 prepare"});
      expect_seg(3'd3, 1'b0, 4, {tag, " R2 HS-0 zero"});
      expect_seg(3'd4, 1'b0, 5, {tag, " R3 pre without ready"});
      expect_seg(3'd4, 1'b1, nr, {tag, " R3 ready"});
   endtask

   task automatic exit_default(input string tag);
      expect_seg(3'd4, 1'b0, 3, {tag, " R4 post"});
      expect_seg(3'd3, 1'b0, 2, {tag, " R4 trail"});
      expect_seg(3'd0, 1'b0, 4, {tag, " R4 back to LP-11"});
   endtask

   task automatic t_reset();
      expect_seg(3'd0, 1'b0, 2, "R1 during reset");
      rst_n = 1'b1;
      expect_seg(3'd0, 1'b0, 3, "R1 after reset");
   endtask

   task automatic t_basic();
      write_cfg(3, 2, 4, 5, 3, 2);
      hs_req = 1'b1;
      entry_default(6, "basic");
      hs_req = 1'b0;
      exit_default("basic");
   endtask

   task automatic t_data_busy();
      hs_req = 1'b1;
      entry_default(2, "busy");
      data_lp = 1'b0;
      hs_req = 1'b0;
      expect_seg(3'd4, 1'b1, 5, "R5 clock held for busy data lane");
      data_lp = 1'b1;
      exit_default("busy");
   endtask

   task automatic t_early_release();
      hs_req = 1'b1;
      expect_seg(3'd1, 1'b0, 1, "R6 first LP-01");
      hs_req = 1'b0;
      expect_seg(3'd1, 1'b0, 2, "R6 LP-01 rest");
      expect_seg(3'd2, 1'b0, 2, "R6 LP-00");
      expect_seg(3'd3, 1'b0, 4, "R6 HS-0");
      expect_seg(3'd4, 1'b0, 5, "R6 pre");
      expect_seg(3'd4, 1'b1, 1, "R6 single ready cycle");
      exit_default("early");
   endtask

   task automatic t_rerequest();
      hs_req = 1'b1;
      entry_default(2, "rereq");
      hs_req = 1'b0;
      expect_seg(3'd4, 1'b0, 1, "R7 post start");
      hs_req = 1'b1;
      expect_seg(3'd4, 1'b0, 2, "R7 post rest");
      expect_seg(3'd3, 1'b0, 2, "R7 trail");
      expect_seg(3'd0, 1'b0, 4, "R7 LP-11 lasts lpx+1");
      entry_default(2, "R7 re-entry");
   endtask

   task automatic t_cfg_gate();
      // lane is running with hs_req high
      write_cfg(5, 5, 5, 5, 7, 6);
      hs_req = 1'b0;
      exit_default("R8 busy write ignored");
      write_cfg(2, 1, 1, 3, 2, 1);
      hs_req = 1'b1;
      expect_seg(3'd1, 1'b0, 2, "R8 new lpx");
      expect_seg(3'd2, 1'b0, 1, "R8 new prepare");
      expect_seg(3'd3, 1'b0, 1, "R8 new zero");
      expect_seg(3'd4, 1'b0, 3, "R8 new pre");
      expect_seg(3'd4, 1'b1, 2, "R8 ready");
      hs_req = 1'b0;
      expect_seg(3'd4, 1'b0, 2, "R8 new post");
      expect_seg(3'd3, 1'b0, 1, "R8 new trail");
      expect_seg(3'd0, 1'b0, 3, "R8 new hold");
   endtask

   task automatic t_zero_vals();
      write_cfg(0, 0, 0, 0, 0, 0);
      hs_req = 1'b1;
      expect_seg(3'd1, 1'b0, 1, "R9 lpx 0");
      expect_seg(3'd2, 1'b0, 1, "R9 prepare 0");
      expect_seg(3'd3, 1'b0, 1, "R9 zero 0");
      expect_seg(3'd4, 1'b0, 1, "R9 pre 0");
      expect_seg(3'd4, 1'b1, 2, "R9 ready");
      hs_req = 1'b0;
      expect_seg(3'd4, 1'b0, 1, "R9 post 0");
      expect_seg(3'd3, 1'b0, 1, "R9 trail 0");
      expect_seg(3'd0, 1'b0, 2, "R9 hold 0");
   endtask

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; hs_req = 1'b0; data_lp = 1'b1;
      cfg_lpx = 1; cfg_prepare = 1; cfg_zero = 1;
      cfg_pre = 1; cfg_post = 1; cfg_trail = 1;
      t_reset();
      t_basic();
      t_data_busy();
      t_early_release();
      t_rerequest();
      t_cfg_gate();
      t_zero_vals();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule